// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance and Acknowledge Controller

This block stands between a processor core and its interrupt sources. It collects requests, keeps them pending, and at each instruction boundary reported by the core it decides whether an interrupt is taken. A request is taken only when its level is above the 3-bit priority mask held in the status word. There is one exception: the top level is non-maskable and is taken when a rising transition is seen on it.

Requests come in one of two ways. In encoded mode they arrive as a 3-bit level. In per-line mode each of three user levels has its own wire. In both modes level 4 belongs to an internal peripheral input.

When a request is taken, the block does the following:
- It keeps a copy of the status word.
- It sets the supervisor bit, clears the trace bit and raises the mask to the taken level.
- It pulses an acknowledge-start signal that carries the level.

The acknowledge then completes in one of three ways. The device can supply a vector number, the system can ask for an autovector derived from the level, or a bus error makes the interrupt spurious. The block presents the resulting vector with a one-cycle strobe.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the status word reads 16'h2700, which is supervisor with mask 7. `sr_saved`, `vec`, `ack_start` and `vec_vld` read 0. With mask 7, a maskable request at a boundary is not taken.
- R2: A maskable request (levels 1 to 6) is taken only when its level is strictly greater than the mask, which is status bits 10:8. A level equal to or below the mask is not taken.
- R3: Acceptance happens only in a cycle where `boundary` is high. A request that was not taken stays pending and is checked again at each later boundary, including after the mask has been lowered.
- R4: On acceptance, `ack_start` is high for exactly one cycle and `ack_lvl` carries the level. `sr_saved` holds the status word as it was before acceptance. In the same cycle `sr_out` shows bit 13 (supervisor) set, bit 15 (trace) cleared and bits 10:8 equal to the level.
- R5: With `mode_ded`=0, `req_enc` is an active-high level, where 0 means no request. The encoded value 4 is ignored.
- R6: With `mode_ded`=1, `req_ded[0]`, `req_ded[1]` and `req_ded[2]` request levels 1, 6 and 7. In this mode `req_enc` is ignored.
- R7: `periph_req` requests level 4 in both modes.
- R8: When several levels are pending, the highest one is the candidate.
- R9: Level 7 is taken even when the mask is 7. It is detected on its rising transition: a level 7 that is held high is taken once and not taken again until it has fallen and risen.
- R10: While an acknowledge is open, `iack_dev` alone makes the next-cycle `vec` equal to `dev_vec`, with `vec_vld` high for one cycle.
- R11: `iack_auto` yields vector 24 plus the level. It takes priority over `iack_dev`.
- R12: `iack_berr` yields the spurious vector 24. It takes priority over the other two responses.
- R13: While an acknowledge is open, boundaries start no new acknowledge. `sr_wr` loads `sr_wdata` into the status word in any cycle without acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ded | input | 1 | 0 encoded requests, 1 per-line requests |
| req_enc | input | 3 | Encoded request level (0 = none) |
| req_ded | input | 3 | Per-line requests for levels 1, 6, 7 |
| periph_req | input | 1 | Internal peripheral request, level 4 |
| boundary | input | 1 | Instruction boundary from the core |
| sr_wr | input | 1 | Status word load strobe |
| sr_wdata | input | 16 | Status word load value |
| iack_dev | input | 1 | Device supplies a vector |
| dev_vec | input | 8 | Device vector number |
| iack_auto | input | 1 | Autovector requested |
| iack_berr | input | 1 | Bus error during acknowledge |
| ack_start | output | 1 | One-cycle acknowledge start |
| ack_lvl | output | 3 | Level being acknowledged |
| vec_vld | output | 1 | Vector strobe |
| vec | output | 8 | Resolved vector number |
| sr_out | output | 16 | Current status word |
| sr_saved | output | 16 | Status word copied at acceptance |

## Verification
A wrong pending register or a wrong edge latch shows at the next boundary: `ack_start` either fails to rise or rises with the wrong `ack_lvl`, one cycle after `boundary`. A wrong status-word update shows in that same cycle on `sr_out` and `sr_saved`. A wrong acknowledge state shows either as a second `ack_start` while a response is still owed or as a missing `vec_vld`, one cycle after the response inputs. A wrong vector selection shows on `vec` in that cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W      = 3;
  localparam int NUM_LVL    = (1 << LVL_W) - 1;
  localparam int VEC_W      = 8;
  localparam int SR_TRACE_B = 15;
  localparam int SR_SUPV_B  = 13;
  localparam int SR_MASK_LO = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ack_st_e;

  // Highest maskable level present in a pending vector (0 = none).
  function automatic logic [LVL_W-1:0] highest_maskable(input logic [NUM_LVL:1] pend);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int l = 1; l < NUM_LVL; l++) begin
      if (pend[l]) r = LVL_W'(l);
    end
    return r;
  endfunction

  // Autovector number: base plus level.
  function automatic logic [VEC_W-1:0] autovec(input logic [VEC_W-1:0] base,
                                               input logic [LVL_W-1:0] lvl);
    return base + {{(VEC_W-LVL_W){1'b0}}, lvl};
  endfunction

  // Strict comparison of a level against the mask.
  function automatic logic beats_mask(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask);
    return lvl > mask;
  endfunction
endpackage

// File: rtl/irq_req_front.sv
module irq_req_front
  import irq_pkg::*;
#(
  parameter int                     DED_N   = 3,
  parameter logic [DED_N*LVL_W-1:0] DED_MAP = {3'd7, 3'd6, 3'd1},
  parameter int                     RSV_LVL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ded,
  input  logic [LVL_W-1:0]   req_enc,
  input  logic [DED_N-1:0]   req_ded,
  input  logic               periph_req,
  input  logic               nmi_clr,
  output logic [NUM_LVL:1]   pend,
  output logic               nmi_edge
);
  logic [NUM_LVL:1] enc_hot;
  logic [NUM_LVL:1] ded_hot;
  logic [NUM_LVL:1] raw;
  logic [NUM_LVL:1] req_q;
  logic             top_d;
  logic             nmi_pend;

  // Encoded mode: one-hot decode, reserved level dropped.
  genvar g;
  generate
    for (g = 1; g <= NUM_LVL; g++) begin : g_enc
      if (g == RSV_LVL) begin : g_rsv
        assign enc_hot[g] = 1'b0;
      end else begin : g_usr
        assign enc_hot[g] = (req_enc == LVL_W'(g));
      end
    end
  endgenerate

  // Per-line mode: each line mapped onto its level.
  always_comb begin
    ded_hot = '0;
    for (int i = 0; i < DED_N; i++) begin
      if (req_ded[i]) ded_hot[DED_MAP[i*LVL_W +: LVL_W]] = 1'b1;
    end
  end

  always_comb begin
    raw = mode_ded ? ded_hot : enc_hot;
    raw[RSV_LVL] = periph_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      top_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      req_q    <= raw;
      top_d    <= req_q[NUM_LVL];
      nmi_pend <= nmi_edge | (nmi_pend & ~nmi_clr);
    end
  end

  assign nmi_edge = req_q[NUM_LVL] & ~top_d;
  assign pend     = {nmi_pend, req_q[NUM_LVL-1:1]};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NUM_LVL:1]  pend,
  input  logic [LVL_W-1:0]  mask,
  output logic [LVL_W-1:0]  win_lvl,
  output logic              win_ok,
  output logic              win_nmi
);
  logic [LVL_W-1:0] mlvl;

  always_comb begin
    mlvl    = highest_maskable(pend);
    win_nmi = pend[NUM_LVL];
    win_lvl = win_nmi ? LVL_W'(NUM_LVL) : mlvl;
    win_ok  = win_nmi | beats_mask(mlvl, mask);
  end
endmodule

// File: rtl/irq_vec_resolve.sv
module irq_vec_resolve
  import irq_pkg::*;
#(
  parameter logic [VEC_W-1:0] AUTO_BASE = 8'd24,
  parameter logic [VEC_W-1:0] SPUR_VEC  = 8'd24
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic             dev_vld,
  input  logic [VEC_W-1:0] dev_vec,
  input  logic             auto_req,
  input  logic             berr,
  output logic             resp_any,
  output logic [VEC_W-1:0] vec_out
);
  always_comb begin
    resp_any = dev_vld | auto_req | berr;
    if (berr)          vec_out = SPUR_VEC;
    else if (auto_req) vec_out = autovec(AUTO_BASE, lvl);
    else               vec_out = dev_vec;
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int                     SR_W      = 16,
  parameter logic [SR_W-1:0]        SR_RST    = 16'h2700,
  parameter logic [VEC_W-1:0]       AUTO_BASE = 8'd24,
  parameter logic [VEC_W-1:0]       SPUR_VEC  = 8'd24,
  parameter int                     RSV_LVL   = 4,
  parameter int                     DED_N     = 3,
  parameter logic [DED_N*LVL_W-1:0] DED_MAP   = {3'd7, 3'd6, 3'd1}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ded,
  input  logic [LVL_W-1:0]   req_enc,
  input  logic [DED_N-1:0]   req_ded,
  input  logic               periph_req,
  input  logic               boundary,
  input  logic               sr_wr,
  input  logic [SR_W-1:0]    sr_wdata,
  input  logic               iack_dev,
  input  logic [VEC_W-1:0]   dev_vec,
  input  logic               iack_auto,
  input  logic               iack_berr,
  output logic               ack_start,
  output logic [LVL_W-1:0]   ack_lvl,
  output logic               vec_vld,
  output logic [VEC_W-1:0]   vec,
  output logic [SR_W-1:0]    sr_out,
  output logic [SR_W-1:0]    sr_saved
);
  ack_st_e          st_q;
  logic [SR_W-1:0]  sr_q;
  logic [SR_W-1:0]  sr_taken;
  logic [NUM_LVL:1] pend;
  logic             nmi_edge;
  logic             nmi_clr;
  logic [LVL_W-1:0] win_lvl;
  logic             win_ok;
  logic             win_nmi;
  logic             resp_any;
  logic [VEC_W-1:0] res_vec;

  // Named internal events.
  logic st_wait;
  logic accept_evt;
  logic resp_evt;

  assign st_wait    = (st_q == ST_WAIT);
  assign accept_evt = ~st_wait & boundary & win_ok;
  assign resp_evt   = st_wait & resp_any;
  assign nmi_clr    = accept_evt & win_nmi;

  irq_req_front #(
    .DED_N   (DED_N),
    .DED_MAP (DED_MAP),
    .RSV_LVL (RSV_LVL)
  ) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_ded   (mode_ded),
    .req_enc    (req_enc),
    .req_ded    (req_ded),
    .periph_req (periph_req),
    .nmi_clr    (nmi_clr),
    .pend       (pend),
    .nmi_edge   (nmi_edge)
  );

  irq_arbiter u_arb (
    .pend    (pend),
    .mask    (sr_q[SR_MASK_LO +: LVL_W]),
    .win_lvl (win_lvl),
    .win_ok  (win_ok),
    .win_nmi (win_nmi)
  );

  irq_vec_resolve #(
    .AUTO_BASE (AUTO_BASE),
    .SPUR_VEC  (SPUR_VEC)
  ) u_vec (
    .lvl      (ack_lvl),
    .dev_vld  (iack_dev),
    .dev_vec  (dev_vec),
    .auto_req (iack_auto),
    .berr     (iack_berr),
    .resp_any (resp_any),
    .vec_out  (res_vec)
  );

  // Status word as it becomes on acceptance.
  always_comb begin
    sr_taken                          = sr_q;
    sr_taken[SR_TRACE_B]              = 1'b0;
    sr_taken[SR_SUPV_B]               = 1'b1;
    sr_taken[SR_MASK_LO +: LVL_W]     = win_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sr_q      <= SR_RST;
      sr_saved  <= '0;
      ack_start <= 1'b0;
      ack_lvl   <= '0;
      vec_vld   <= 1'b0;
      vec       <= '0;
    end else begin
      ack_start <= accept_evt;
      vec_vld   <= resp_evt;
      if (accept_evt) begin
        sr_saved <= sr_q;
        sr_q     <= sr_taken;
        ack_lvl  <= win_lvl;
        st_q     <= ST_WAIT;
      end else begin
        if (sr_wr) sr_q <= sr_wdata;
        if (resp_evt) begin
          vec  <= res_vec;
          st_q <= ST_IDLE;
        end
      end
    end
  end

  assign sr_out = sr_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_pkg::*;
#(
  parameter int               SR_W      = 16,
  parameter logic [VEC_W-1:0] AUTO_BASE = 8'd24,
  parameter logic [VEC_W-1:0] SPUR_VEC  = 8'd24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary,
  input logic             ack_start,
  input logic [LVL_W-1:0] ack_lvl,
  input logic [SR_W-1:0]  sr_out,
  input logic [SR_W-1:0]  sr_saved,
  input logic             vec_vld,
  input logic [VEC_W-1:0] vec,
  input logic             st_wait,
  input logic             iack_dev,
  input logic [VEC_W-1:0] dev_vec,
  input logic             iack_auto,
  input logic             iack_berr
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> !ack_start); // R4
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> $past(boundary)); // R3
  AST_ACK_OVER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> (ack_lvl == 3'd7 || ack_lvl > sr_saved[SR_MASK_LO +: LVL_W])); // R2
  AST_SR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> (sr_out[SR_MASK_LO +: LVL_W] == ack_lvl && sr_out[SR_SUPV_B] && !sr_out[SR_TRACE_B])); // R4
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> ack_lvl != '0); // R5
  AST_NO_NESTED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && boundary) |=> !ack_start); // R13
  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && iack_berr) |=> (vec_vld && vec == SPUR_VEC)); // R12
  AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && !iack_berr && iack_auto) |=> (vec_vld && vec == AUTO_BASE + VEC_W'(ack_lvl))); // R11
  AST_DEVVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && !iack_berr && !iack_auto && iack_dev) |=> (vec_vld && vec == $past(dev_vec))); // R10
endmodule

bind irq_accept_ctrl irq_accept_chk #(
  .SR_W      (SR_W),
  .AUTO_BASE (AUTO_BASE),
  .SPUR_VEC  (SPUR_VEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boundary  (boundary),
  .ack_start (ack_start),
  .ack_lvl   (ack_lvl),
  .sr_out    (sr_out),
  .sr_saved  (sr_saved),
  .vec_vld   (vec_vld),
  .vec       (vec),
  .st_wait   (st_wait),
  .iack_dev  (iack_dev),
  .dev_vec   (dev_vec),
  .iack_auto (iack_auto),
  .iack_berr (iack_berr)
);

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_ded;
  logic [2:0]  req_enc;
  logic [2:0]  req_ded;
  logic        periph_req;
  logic        boundary;
  logic        sr_wr;
  logic [15:0] sr_wdata;
  logic        iack_dev;
  logic [7:0]  dev_vec;
  logic        iack_auto;
  logic        iack_berr;
  logic        ack_start;
  logic [2:0]  ack_lvl;
  logic        vec_vld;
  logic [7:0]  vec;
  logic [15:0] sr_out;
  logic [15:0] sr_saved;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_accept_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_ded(mode_ded), .req_enc(req_enc),
    .req_ded(req_ded), .periph_req(periph_req), .boundary(boundary),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .iack_dev(iack_dev), .dev_vec(dev_vec),
    .iack_auto(iack_auto), .iack_berr(iack_berr), .ack_start(ack_start),
    .ack_lvl(ack_lvl), .vec_vld(vec_vld), .vec(vec), .sr_out(sr_out),
    .sr_saved(sr_saved)
  );

  // rsp: 0 device, 1 auto, 2 berr+auto+device, 3 auto+device
  typedef struct packed {
    logic       mode;
    logic [2:0] enc;
    logic [2:0] ded;
    logic       per;
    logic [2:0] mask;
    logic [1:0] rsp;
    logic [7:0] dvec;
    logic       acc;
    logic [2:0] lvl;
  } row_t;

  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 3'd3, 3'd0, 1'b0, 3'd2, 2'd0, 8'h40, 1'b1, 3'd3}, // R2 R10
    '{1'b0, 3'd3, 3'd0, 1'b0, 3'd3, 2'd0, 8'h00, 1'b0, 3'd0}, // R2 equal
    '{1'b0, 3'd5, 3'd0, 1'b0, 3'd0, 2'd1, 8'h00, 1'b1, 3'd5}, // R11
    '{1'b0, 3'd4, 3'd0, 1'b0, 3'd0, 2'd0, 8'h00, 1'b0, 3'd0}, // R5 reserved code
    '{1'b0, 3'd4, 3'd0, 1'b1, 3'd3, 2'd1, 8'h00, 1'b1, 3'd4}, // R7
    '{1'b0, 3'd2, 3'd0, 1'b1, 3'd0, 2'd0, 8'h55, 1'b1, 3'd4}, // R8
    '{1'b0, 3'd6, 3'd0, 1'b1, 3'd5, 2'd2, 8'h12, 1'b1, 3'd6}, // R8 R12
    '{1'b0, 3'd7, 3'd0, 1'b0, 3'd7, 2'd1, 8'h00, 1'b1, 3'd7}, // R9
    '{1'b1, 3'd0, 3'd1, 1'b0, 3'd0, 2'd1, 8'h00, 1'b1, 3'd1}, // R6
    '{1'b1, 3'd5, 3'd2, 1'b0, 3'd2, 2'd0, 8'h99, 1'b1, 3'd6}, // R6
    '{1'b1, 3'd6, 3'd0, 1'b0, 3'd0, 2'd0, 8'h00, 1'b0, 3'd0}, // R6 enc ignored
    '{1'b1, 3'd0, 3'd4, 1'b0, 3'd7, 2'd2, 8'h00, 1'b1, 3'd7}, // R9 R12
    '{1'b1, 3'd0, 3'd3, 1'b1, 3'd6, 2'd0, 8'h00, 1'b0, 3'd0}, // R2 R7
    '{1'b0, 3'd1, 3'd0, 1'b0, 3'd0, 2'd3, 8'h3c, 1'b1, 3'd1}  // R11 priority
  };

  function automatic int exp_vec(input logic [1:0] rsp, input logic [2:0] lvl,
                                 input logic [7:0] dv);
    case (rsp)
      2'd0:    return int'(dv);
      2'd2:    return 24;
      default: return 24 + int'(lvl);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sr(input logic [15:0] v);
    sr_wr = 1'b1; sr_wdata = v;
    tick(1);
    sr_wr = 1'b0;
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1;
    tick(1);
    boundary = 1'b0;
  endtask

  task automatic respond(input logic [1:0] rsp, input logic [7:0] dv);
    iack_dev  = (rsp != 2'd1);
    iack_auto = (rsp != 2'd0);
    iack_berr = (rsp == 2'd2);
    dev_vec   = dv;
    tick(1);
    iack_dev = 1'b0; iack_auto = 1'b0; iack_berr = 1'b0;
  endtask

  task automatic clear_reqs();
    req_enc = '0; req_ded = '0; periph_req = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_ded = 1'b0; req_enc = '0; req_ded = '0; periph_req = 1'b0;
    boundary = 1'b0; sr_wr = 1'b0; sr_wdata = '0; iack_dev = 1'b0; dev_vec = '0;
    iack_auto = 1'b0; iack_berr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset values
    chk(sr_out == 16'h2700, "R1 sr_out", int'(sr_out), 'h2700);
    chk(sr_saved == 16'h0, "R1 sr_saved", int'(sr_saved), 0);
    chk(!ack_start && !vec_vld, "R1 strobes", int'({ack_start, vec_vld}), 0);
    chk(vec == 8'h0, "R1 vec", int'(vec), 0);
    // R1 mask 7 after reset blocks a maskable level
    req_enc = 3'd6;
    tick(3);
    pulse_boundary();
    chk(!ack_start, "R1 mask7 blocks level 6", int'(ack_start), 0);
    clear_reqs();

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      logic [15:0] prev;
      prev = 16'h8000 | (16'(TBL[i].mask) << 8);
      mode_ded = TBL[i].mode; req_enc = TBL[i].enc; req_ded = TBL[i].ded;
      periph_req = TBL[i].per;
      write_sr(prev);
      tick(2);
      pulse_boundary();
      chk(ack_start == TBL[i].acc, $sformatf("R2/R5-R9 row %0d accept", i),
          int'(ack_start), int'(TBL[i].acc));
      if (TBL[i].acc) begin
        chk(ack_lvl == TBL[i].lvl, $sformatf("R8 row %0d level", i),
            int'(ack_lvl), int'(TBL[i].lvl));
        chk(sr_out == (16'h2000 | (16'(TBL[i].lvl) << 8)),
            $sformatf("R4 row %0d sr_out", i), int'(sr_out),
            int'(16'h2000 | (16'(TBL[i].lvl) << 8)));
        chk(sr_saved == prev, $sformatf("R4 row %0d sr_saved", i),
            int'(sr_saved), int'(prev));
        respond(TBL[i].rsp, TBL[i].dvec);
        chk(!ack_start, $sformatf("R4 row %0d pulse width", i), int'(ack_start), 0);
        chk(vec_vld, $sformatf("R10/R11/R12 row %0d strobe", i), int'(vec_vld), 1);
        chk(int'(vec) == exp_vec(TBL[i].rsp, TBL[i].lvl, TBL[i].dvec),
            $sformatf("R10/R11/R12 row %0d vector", i), int'(vec),
            exp_vec(TBL[i].rsp, TBL[i].lvl, TBL[i].dvec));
        tick(1);
        chk(!vec_vld, $sformatf("R10 row %0d strobe width", i), int'(vec_vld), 0);
      end
      clear_reqs();
    end

    // R3: pending without boundary, rejected, then re-evaluated after mask drop
    mode_ded = 1'b0;
    write_sr(16'h0000);
    req_enc = 3'd5;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      chk(!ack_start, "R3 no boundary no accept", int'(ack_start), 0);
    end
    write_sr(16'h0600);
    pulse_boundary();
    chk(!ack_start, "R3 rejected at mask 6", int'(ack_start), 0);
    write_sr(16'h0200);
    pulse_boundary();
    chk(ack_start && ack_lvl == 3'd5, "R3 accepted after mask drop",
        int'({ack_start, ack_lvl}), 'hd);
    chk(sr_saved == 16'h0200, "R3 saved word", int'(sr_saved), 'h200);
    respond(2'd0, 8'h21);
    chk(vec == 8'h21, "R10 device vector", int'(vec), 'h21);
    clear_reqs();

    // R9: held level 7 is taken once only
    write_sr(16'h0000);
    req_enc = 3'd7;
    tick(3);
    pulse_boundary();
    chk(ack_start && ack_lvl == 3'd7, "R9 first edge taken", int'({ack_start, ack_lvl}), 'hf);
    respond(2'd1, 8'h00);
    chk(vec == 8'd31, "R11 level 7 autovector", int'(vec), 31);
    write_sr(16'h0000);
    tick(2);
    pulse_boundary();
    chk(!ack_start, "R9 held level 7 not retaken", int'(ack_start), 0);
    req_enc = 3'd0;
    tick(2);
    req_enc = 3'd7;
    tick(3);
    pulse_boundary();
    chk(ack_start && ack_lvl == 3'd7, "R9 new edge taken", int'({ack_start, ack_lvl}), 'hf);
    respond(2'd2, 8'h00);
    chk(vec == 8'd24, "R12 spurious", int'(vec), 24);
    clear_reqs();

    // R13: no nested acknowledge, SR load while idle
    write_sr(16'h0000);
    req_enc = 3'd3;
    tick(2);
    pulse_boundary();
    chk(ack_start && ack_lvl == 3'd3, "R13 first accept", int'({ack_start, ack_lvl}), 'hb);
    req_enc = 3'd6;
    tick(2);
    pulse_boundary();
    chk(!ack_start, "R13 boundary while waiting", int'(ack_start), 0);
    respond(2'd0, 8'h77);
    chk(vec_vld && vec == 8'h77, "R13 open acknowledge completes", int'(vec), 'h77);
    pulse_boundary();
    chk(ack_start && ack_lvl == 3'd6, "R13 next accept after completion",
        int'({ack_start, ack_lvl}), 'he);
    respond(2'd1, 8'h00);
    clear_reqs();
    write_sr(16'h8123);
    chk(sr_out == 16'h8123, "R13 status load", int'(sr_out), 'h8123);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule